// File: doc/BRIEF.md
# Big-Endian Subword Data Memory

A data memory organised as words of eight bytes. Each request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a store value and separate load and store strobes. Within each word the bytes are numbered from the most significant end. A narrow store reads the addressed word, replaces only the bytes it covers and writes the word back. A narrow load returns the whole word with every byte outside the access forced to zero. The selected bytes stay where they sit in the word and are not moved down to bit 0.

A request whose byte offset is not a multiple of its size is refused. The memory is left as it was, no load result is produced, and a one-cycle error pulse reports the refusal. Load results arrive one cycle after the request. The storage is cleared by reset.

Top module: `subword_mem`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ld_valid` and `misalign` are low. After reset every word reads as zero.
- R2: The word index is `addr >> 3` and the byte offset is `addr[2:0]`. A size-8 access (`size` = 3, offset 0) stores or returns all 64 bits unchanged.
- R3: `size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A request with a nonzero `offset mod width` raises `misalign` for exactly the next cycle and does not assert `ld_valid`. Such a request leaves every memory word unchanged.
- R4: Byte lanes are big-endian. Offset k occupies bits `63-8k` down to `56-8k`. For a width w, the store value's low w bytes are placed from the access offset onward, with the most significant of those bytes at the lowest offset. This equals a left shift of `((8 - w) - offset) * 8` bits.
- R5: An aligned narrow store changes only the addressed lanes. Bits of `st_data` above the low `w*8` bits have no effect.
- R6: An aligned narrow load returns the stored word ANDed with the lane mask, in place. All bits outside the addressed lanes are zero.
- R7: An aligned load raises `ld_valid` for one cycle, one cycle after the request, with `ld_data` valid in that same cycle. When there is no aligned load request, `ld_valid` is low in the next cycle.
- R8: A load in the cycle right after a store to the same word returns the stored data.
- R9: A load and a store in the same cycle to the same word return the contents from before the store. The store still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears storage |
| ld_en | input | 1 | Load request strobe |
| st_en | input | 1 | Store request strobe |
| addr | input | ADDR_W (11) | Byte address |
| size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_data | input | 64 | Store value, right-aligned |
| ld_data | output | 64 | Masked load word, lanes in place |
| ld_valid | output | 1 | Load result valid |
| misalign | output | 1 | Alignment error pulse |

## Verification
Every result is due exactly one clock edge after the request that causes it. This covers `ld_valid`, `ld_data` and `misalign`, and a store's effect on a load issued in the following cycle. The bench applies each request at a falling edge and compares all three outputs at the next falling edge. At that point the new request is already applied, so operations run back to back, as in R8. The reference word is read before a store updates it, which yields the pre-store value required for same-cycle loads and stores (R9).

// File: rtl/subword_mem.sv
module subword_mem #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH) + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [63:0]       st_data,
  output logic [63:0]       ld_data,
  output logic              ld_valid,
  output logic              misalign
);
  localparam int IDX_W = ADDR_W - 3;

  logic [63:0] mem [DEPTH];

  logic [IDX_W-1:0] idx;
  logic [2:0]       off;
  logic [3:0]       nbytes;
  logic             ok;
  logic [6:0]       shift;
  logic [63:0]      mask;
  logic [63:0]      merged;

  assign idx    = addr[ADDR_W-1:3];
  assign off    = addr[2:0];
  assign nbytes = 4'd1 << size;
  assign ok     = ({1'b0, off} & (nbytes - 4'd1)) == 4'd0;
  assign shift  = {(4'd8 - nbytes - {1'b0, off}), 3'b000};
  assign mask   = (size == 2'd3) ? '1
                : (((64'd1 << {nbytes, 3'b000}) - 64'd1) << shift);
  assign merged = (mem[idx] & ~mask) | ((st_data << shift) & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ld_valid <= 1'b0;
      misalign <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_en && ok;
      misalign <= (ld_en || st_en) && !ok;
      if (ld_en && ok) ld_data <= mem[idx] & mask;
      if (st_en && ok) mem[idx] <= merged;
    end
  end
endmodule

// File: rtl/subword_mem_chk.sv
module subword_mem_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic              st_en,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        size,
  input logic [63:0]       ld_data,
  input logic              ld_valid,
  input logic              misalign
);
  logic [63:0] cmask;
  logic        legal;

  always_comb begin
    int w;
    int o;
    w = 1 << size;
    o = int'(addr[2:0]);
    legal = (o % w) == 0;
    cmask = '0;
    for (int lane = 0; lane < 8; lane++)
      if (lane >= o && lane < o + w) cmask[63-8*lane -: 8] = 8'hFF;
  end

  p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en || st_en) && !legal |=> misalign && !ld_valid);

  p_load_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && legal |=> ld_valid && !misalign);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en && !st_en |=> !ld_valid && !misalign);

  p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && legal |=> (ld_data & ~$past(cmask)) == 64'd0);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !ld_valid && !misalign);
endmodule

bind subword_mem subword_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .st_en(st_en), .addr(addr),
  .size(size), .ld_data(ld_data), .ld_valid(ld_valid), .misalign(misalign)
);

// File: tb/subword_mem_bench.sv
module subword_mem_bench;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, st_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] size = '0;
  logic [63:0] st_data = '0;
  logic [63:0] ld_data;
  logic ld_valid, misalign;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [63:0] model [DEPTH];

  always #2.5 clk = ~clk;

  subword_mem #(.DEPTH(DEPTH)) u_subword_mem (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .st_en(st_en), .addr(addr),
    .size(size), .st_data(st_data), .ld_data(ld_data),
    .ld_valid(ld_valid), .misalign(misalign)
  );

  function automatic logic [63:0] lane_mask(logic [1:0] sz, int o);
    logic [63:0] m = '0;
    int w = 1 << sz;
    for (int k = 0; k < w; k++) m[63-8*(o+k) -: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [63:0] place(logic [1:0] sz, int o, logic [63:0] d);
    logic [63:0] r = '0;
    int w = 1 << sz;
    for (int k = 0; k < w; k++) r[63-8*(o+k) -: 8] = d[8*(w-1-k) +: 8];
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, bit l, bit s, int word, int o, logic [1:0] sz,
                    logic [63:0] d);
    int w = 1 << sz;
    bit legal = (o % w) == 0;
    logic [63:0] exp_ld;
    ld_en = l; st_en = s; size = sz; st_data = d;
    addr = AW'((word << 3) | o);
    exp_ld = model[word] & lane_mask(sz, o);
    if (s && legal)
      model[word] = (model[word] & ~lane_mask(sz, o)) | place(sz, o, d);
    @(negedge clk);
    chk({tag, " ld_valid"}, 64'(ld_valid), 64'(l && legal));
    chk({tag, " misalign"}, 64'(misalign), 64'((l || s) && !legal));
    if (l && legal) chk({tag, " ld_data"}, ld_data, exp_ld);
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: got hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 ld_valid in reset", 64'(ld_valid), 64'd0);
    chk("R1 misalign in reset", 64'(misalign), 64'd0);
    rst_n = 1'b1;
    op("R1 idle", 0, 0, 0, 0, 2'd0, '0);
    op("R1 zero read", 1, 0, 9, 0, 2'd3, '0);
    op("R2 full store", 0, 1, 3, 0, 2'd3, 64'h0123_4567_89AB_CDEF);
    op("R8 full load next cycle", 1, 0, 3, 0, 2'd3, '0);
    op("R4 byte at off0", 0, 1, 5, 0, 2'd0, 64'hFFFF_FFFF_FFFF_FFA5);
    op("R4 full readback", 1, 0, 5, 0, 2'd3, '0);
    op("R5 half at off6", 0, 1, 3, 6, 2'd1, 64'hDEAD_BEEF_0000_1122);
    op("R5 preserve others", 1, 0, 3, 0, 2'd3, '0);
    op("R6 word load off4", 1, 0, 3, 4, 2'd2, '0);
    op("R6 byte load off7", 1, 0, 3, 7, 2'd0, '0);
    op("R3 misaligned store", 0, 1, 3, 2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    op("R3 unchanged", 1, 0, 3, 0, 2'd3, '0);
    op("R3 misaligned load", 1, 0, 3, 1, 2'd1, '0);
    op("R3 misaligned full", 0, 1, 3, 4, 2'd3, 64'h1);
    op("R9 same cycle ld st", 1, 1, 3, 0, 2'd3, 64'hCAFE_F00D_1234_5678);
    op("R9 store took effect", 1, 0, 3, 0, 2'd3, '0);
    op("R7 idle after load", 0, 0, 0, 0, 2'd0, '0);
    for (int n = 0; n < 2000; n++) begin
      bit l = $urandom_range(0, 1) == 1;
      bit s = $urandom_range(0, 2) == 0;
      logic [63:0] d = {$urandom, $urandom};
      op("R2 R4 R5 R6 R8 random", l, s, int'($urandom_range(0, 15)),
         int'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), d);
    end
    for (int wd = 0; wd < 16; wd++)
      op("R5 final sweep", 1, 0, wd, 0, 2'd3, '0);
    ld_en = 0; st_en = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule